// File: doc/BRIEF.md
# Weighted Serial Polynomial Hash

This block computes a keyed universal hash over a message split into pairs of w-bit words, with w = 64 by default. For each pair it forms a = m_odd XOR k_odd and b = m_even XOR k_even as carry-free polynomial sums over GF(2). It then folds the product a·b into one w-bit accumulator. The accumulator is reduced modulo the irreducible polynomial p(x) = x^64 + x^4 + x^3 + x + 1.

Each pair carries a weight that depends on its position. If there are n/2 pairs, pair i is scaled by x^((n/2−i)·w). The first pair therefore has the highest weight and the last pair has weight one. This weighting lets one shift-and-reduce register serve as both the serial multiplier and the running sum. No separate sum register is needed.

A host uses the block as follows:
- Pulse `start` to clear the accumulator.
- Offer the pairs one at a time on a valid/ready handshake, and mark the final pair with `pair_last`.
- When `done` pulses, read `tag`.

Back-pressure rule: a pair is taken on a rising edge where `pair_valid` and `pair_ready` are both high. `pair_ready` is low while a pair is being multiplied, which takes w cycles. While it is low, the source must hold the pair and `pair_last` stable.

Top module: `wh_hash`

## Requirements
- R1: After reset, `tag` is 0, `done` is 0 and `pair_ready` is 1.
- R2: For a single-pair message, `tag` equals a·b mod p. Bit i of every operand word and of `tag` is the coefficient of x^i. Addition is bitwise XOR. p has the low-order part 64'h1B. For example, a = 1 and b = x^63 gives 64'h8000000000000000, and a = x and b = x^63 gives 64'h1B.
- R3: For a multi-pair message, `tag` = XOR over i of a_i·b_i·x^((n/2−i)·w) mod p. The first pair carries the highest weight, so reversing the order of the pairs changes the tag.
- R4: If the pair marked `pair_last` is accepted at clock edge t, `done` is high only during the cycle that follows edge t+w.
- R5: After a pair is accepted, `pair_ready` is low for exactly w cycles. A pair held on the inputs during that time is taken once, when `pair_ready` returns high.
- R6: `done` pulses for exactly one cycle, and only for a pair marked `pair_last`. There is one pulse per message.
- R7: `start` while `pair_ready` is high clears `tag` to 0 at the next edge. `start` while `pair_ready` is low has no effect on the result.
- R8: While idle, with no `start` and no pair accepted, `tag` holds its value. In particular it holds after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the accumulator when idle |
| pair_valid | input | 1 | A pair is offered on the operand inputs |
| pair_ready | output | 1 | Block can take a pair this cycle |
| pair_last | input | 1 | The offered pair ends the message |
| m_odd | input | W | Odd message word |
| k_odd | input | W | Odd key word |
| m_even | input | W | Even message word |
| k_even | input | W | Even key word |
| done | output | 1 | One-cycle pulse: `tag` is final |
| tag | output | W | Accumulated hash |

## Verification
The hardest situation to reach is a next pair, or a `start`, arriving while a multiplication is still running. The result then depends on the handshake holding the pair back and on `start` being ignored.

The stimulus covers this in two ways:
- It offers each following pair immediately after the previous one is accepted, so every pair spends almost w cycles under back-pressure.
- In one message it pulses `start` in the middle of a pair's multiplication.

Reversed-order and eight-pair messages expose the positional weighting. Operand values chosen to overflow x^63 exercise the reduction taps.

// File: rtl/wh_hash_pkg.sv
package wh_hash_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/wh_operand_mix.sv
module wh_operand_mix #(
  parameter int W = 64
) (
  input  logic [W-1:0] m_odd,
  input  logic [W-1:0] k_odd,
  input  logic [W-1:0] m_even,
  input  logic [W-1:0] k_even,
  output logic [W-1:0] mul_a,
  output logic [W-1:0] mul_b
);
  // carry-free GF(2) sums of message and key words
  always_comb begin
    mul_a = m_odd ^ k_odd;
    mul_b = m_even ^ k_even;
  end
endmodule

// File: rtl/wh_step_ctrl.sv
module wh_step_ctrl
  import wh_hash_pkg::*;
#(
  parameter int W = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic last_in,
  output logic busy,
  output logic step_en,
  output logic done_pulse
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(W - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      cnt_q      <= '0;
      last_q     <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
            last_q  <= last_in;
          end
        end
        SEQ_RUN: begin
          if (cnt_q == CNT_END) begin
            state_q    <= SEQ_IDLE;
            done_pulse <= last_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    busy    = (state_q == SEQ_RUN);
    step_en = busy;
  end
endmodule

// File: rtl/wh_shift_reduce.sv
module wh_shift_reduce #(
  parameter int           W        = 64,
  parameter logic [W-1:0] POLY_LOW = 64'h1B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] acc
);
  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  logic [W-1:0] acc_q;
  logic [W-1:0] acc_nxt;
  logic         top_bit;
  logic         scan_bit;

  assign top_bit  = acc_q[W-1];
  assign scan_bit = b_q[W-1];

  // per-bit next value: (acc*x mod p) xor (scanned b bit ? a : 0)
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    if (gi == 0) begin : g_lsb
      assign acc_nxt[gi] = (POLY_LOW[gi] & top_bit) ^ (scan_bit & a_q[gi]);
    end else begin : g_upper
      assign acc_nxt[gi] = acc_q[gi-1] ^ (POLY_LOW[gi] & top_bit) ^ (scan_bit & a_q[gi]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
    end else begin
      if (step) begin
        acc_q <= acc_nxt;
        b_q   <= {b_q[W-2:0], 1'b0};
      end else begin
        if (clear) acc_q <= '0;
        if (load) begin
          a_q <= a_in;
          b_q <= b_in;
        end
      end
    end
  end

  assign acc = acc_q;
endmodule

// File: rtl/wh_hash.sv
module wh_hash #(
  parameter int           W        = 64,
  parameter logic [W-1:0] POLY_LOW = 64'h1B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         pair_valid,
  output logic         pair_ready,
  input  logic         pair_last,
  input  logic [W-1:0] m_odd,
  input  logic [W-1:0] k_odd,
  input  logic [W-1:0] m_even,
  input  logic [W-1:0] k_even,
  output logic         done,
  output logic [W-1:0] tag
);
  logic [W-1:0] mul_a;
  logic [W-1:0] mul_b;
  logic         busy;
  logic         step_en;
  logic         accept;
  logic         clear;

  assign pair_ready = ~busy;
  assign accept     = pair_valid & ~busy;
  assign clear      = start & ~busy;

  wh_operand_mix #(.W(W)) u_mix (
    .m_odd (m_odd),
    .k_odd (k_odd),
    .m_even(m_even),
    .k_even(k_even),
    .mul_a (mul_a),
    .mul_b (mul_b)
  );

  wh_step_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .last_in   (pair_last),
    .busy      (busy),
    .step_en   (step_en),
    .done_pulse(done)
  );

  wh_shift_reduce #(.W(W), .POLY_LOW(POLY_LOW)) u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(clear),
    .load (accept),
    .step (step_en),
    .a_in (mul_a),
    .b_in (mul_b),
    .acc  (tag)
  );
endmodule

// File: rtl/wh_hash_chk.sv
module wh_hash_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         pair_valid,
  input logic         pair_ready,
  input logic         done,
  input logic [W-1:0] tag
);
  localparam int LW = $clog2(W + 1) + 1;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (!pair_ready) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  // R6: done is a single-cycle pulse
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: acceptance drops ready on the next cycle
  p_ready_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_ready) |=> !pair_ready);

  // R5: ready stays low for exactly W cycles
  p_ready_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_ready && $past(!pair_ready)) |-> (low_cnt == LW'(W)));

  // R4: done appears just as the multiplication finishes
  p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pair_ready && $past(!pair_ready)));

  // R7: start while idle clears the tag
  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pair_ready) |=> (tag == '0));

  // R8: idle tag holds without start or pair
  p_tag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_ready && !start && !pair_valid) |=> $stable(tag));
endmodule

bind wh_hash wh_hash_chk #(.W(W)) u_wh_hash_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .pair_valid(pair_valid),
  .pair_ready(pair_ready),
  .done      (done),
  .tag       (tag)
);

// File: tb/wh_hash_bench.sv
module wh_hash_bench;
  localparam int W = 64;
  localparam logic [2*W-1:0] PFULL = {{(W-1){1'b0}}, 1'b1, 64'h1B};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         pair_valid = 1'b0;
  logic         pair_ready;
  logic         pair_last = 1'b0;
  logic [W-1:0] m_odd = '0, k_odd = '0, m_even = '0, k_even = '0;
  logic         done;
  logic [W-1:0] tag;

  int checks = 0;
  int fails = 0;
  int dones = 0;
  bit finished = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_tag;
  logic [W-1:0] pm1[8], pk1[8], pm2[8], pk2[8];
  logic [W-1:0] rng = 64'h9E3779B97F4A7C15;

  always #2 clk = ~clk;

  wh_hash #(.W(W)) u_wh_hash (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pair_valid(pair_valid), .pair_ready(pair_ready), .pair_last(pair_last),
    .m_odd(m_odd), .k_odd(k_odd), .m_even(m_even), .k_even(k_even),
    .done(done), .tag(tag)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] clmul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] r = '0;
    for (int i = 0; i < W; i++)
      if (b[i]) r = r ^ ({{W{1'b0}}, a} << i);
    return r;
  endfunction

  function automatic logic [W-1:0] reduce(input logic [2*W-1:0] x);
    logic [2*W-1:0] v = x;
    for (int i = 2*W-1; i >= W; i--)
      if (v[i]) v = v ^ (PFULL << (i - W));
    return v[W-1:0];
  endfunction

  function automatic logic [W-1:0] model(input int n);
    logic [W-1:0] acc = '0;
    for (int i = 0; i < n; i++)
      acc = reduce({acc, {W{1'b0}}}) ^ reduce(clmul(pm1[i] ^ pk1[i], pm2[i] ^ pk2[i]));
    return acc;
  endfunction

  function automatic logic [W-1:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  // monitor: compare every done against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      dones++;
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected done", tag, '0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(tag == e, "R2/R3 tag", tag, e);
      end
      last_tag = tag;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic send_pair(input int i, input bit last);
    @(negedge clk);
    pair_valid = 1'b1; pair_last = last;
    m_odd = pm1[i]; k_odd = pk1[i]; m_even = pm2[i]; k_even = pk2[i];
    while (!pair_ready) @(negedge clk);
    @(negedge clk);
    pair_valid = 1'b0; pair_last = 1'b0;
    m_odd = '1; k_odd = '0; m_even = '1; k_even = '0;
  endtask

  task automatic run_msg(input int n, input bit mid_start);
    int d0, k, lows;
    logic [W-1:0] e;
    e = model(n);
    exp_q.push_back(e);
    d0 = dones;
    pulse_start();
    chk(tag == '0, "R7 start clears", tag, '0);
    for (int i = 0; i < n; i++) begin
      send_pair(i, i == n - 1);
      if (mid_start && i == 0) begin
        start = 1'b1;
        @(negedge clk) start = 1'b0;
      end
    end
    k = 1; lows = 0;
    while (!done) begin
      if (!pair_ready) lows++;
      @(negedge clk);
      k++;
    end
    if (!mid_start || n > 1) begin
      chk(k == W + 1, "R4 latency", W'(k), W'(W + 1));
      chk(lows == W, "R5 ready low window", W'(lows), W'(W));
    end
    @(negedge clk);
    chk(done == 1'b0, "R6 one-cycle done", W'(done), '0);
    chk(dones == d0 + 1, "R6 one done per message", W'(dones - d0), W'(1));
    repeat (3) @(negedge clk);
    chk(tag == e, "R8 tag holds", tag, e);
  endtask

  task automatic fill_rand(input int n);
    for (int i = 0; i < n; i++) begin
      pm1[i] = next_rand(); pk1[i] = next_rand();
      pm2[i] = next_rand(); pk2[i] = next_rand();
    end
  endtask

  initial begin
    logic [W-1:0] t_fwd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(tag == '0, "R1 reset tag", tag, '0);
    chk(done == 1'b0, "R1 reset done", W'(done), '0);
    chk(pair_ready == 1'b1, "R1 reset ready", W'(pair_ready), W'(1));

    // R2: known single-pair vectors
    pm1[0] = 64'h1; pk1[0] = '0; pm2[0] = 64'h8000000000000000; pk2[0] = '0;
    run_msg(1, 0);
    chk(last_tag == 64'h8000000000000000, "R2 x^63", last_tag, 64'h8000000000000000);
    pm1[0] = 64'h3; pk1[0] = 64'h1; pm2[0] = 64'h0; pk2[0] = 64'h8000000000000000;
    run_msg(1, 0);
    chk(last_tag == 64'h1B, "R2 x^64 reduce", last_tag, 64'h1B);

    // R2: zero operand and all-ones operand
    pm1[0] = 64'h1234; pk1[0] = 64'h1234; pm2[0] = '1; pk2[0] = '0;
    run_msg(1, 0);
    chk(last_tag == '0, "R2 zero a", last_tag, '0);
    pm1[0] = '1; pk1[0] = '0; pm2[0] = '1; pk2[0] = '0;
    run_msg(1, 0);

    // R3: order weighting
    fill_rand(2);
    run_msg(2, 0);
    t_fwd = last_tag;
    begin
      logic [W-1:0] s;
      s = pm1[0]; pm1[0] = pm1[1]; pm1[1] = s;
      s = pk1[0]; pk1[0] = pk1[1]; pk1[1] = s;
      s = pm2[0]; pm2[0] = pm2[1]; pm2[1] = s;
      s = pk2[0]; pk2[0] = pk2[1]; pk2[1] = s;
    end
    run_msg(2, 0);
    chk(last_tag != t_fwd, "R3 order changes tag", last_tag, t_fwd);

    // R3: longer messages
    fill_rand(3); run_msg(3, 0);
    fill_rand(8); run_msg(8, 0);

    // R7: start in mid-multiplication ignored
    fill_rand(3); run_msg(3, 1);

    // R7: explicit clear after a result
    pulse_start();
    chk(tag == '0, "R7 idle start clears", tag, '0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all results seen", W'(exp_q.size()), '0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule